// File: doc/BRIEF.md
# Serial ADC Power-State Tracker

This block models the digital power-management side of a 16-clock serial sampling converter, as seen from the device. It runs on a fast system clock, samples the active-low chip select and the serial clock as synchronous inputs, and counts the serial-clock falling edges that occur while chip select stays low. When chip select rises, the count chooses the next power state. The choice depends on the state the frame started in: normal operation, a shallow power-down that keeps the bias circuit alive, or a deep power-down.

During a frame that starts in normal operation, the block shifts out a 16-bit word, MSB first. The word is two zero bits, then the parallel conversion result, then zero padding. The data pin is released whenever chip select is high, so a frame that is cut short leaves the line undriven at once. A frame that starts in either power-down state is a wake-up (dummy) frame. It carries no data, and the block raises flags for the wake-up and for the front end's return to tracking. A host-controller bench can use the block as a reference: its state output shows what the converter would do with any chip-select and clock pattern.

Top module: `adc_pm_tracker`

## Requirements
- R1: When `rst_n` is sampled low, the block enters the state set by `INIT_MODE` (encoding: 0 = normal, 1 = shallow power-down, 2 = deep power-down). It also clears `sdo_en`, `frame_valid` and `waking`, and sets `track` high only when that initial state is normal.
- R2: From normal, a chip-select rise after fewer than 2 serial-clock falling edges leaves the state at normal (glitch guard).
- R3: From normal, a chip-select rise after 2 to 9 falling edges moves the state to shallow power-down.
- R4: From normal, a chip-select rise after 10 or more falling edges keeps the state at normal, even when fewer than 16 edges were given.
- R5: From shallow power-down, a chip-select rise after 0 to 9 falling edges moves to deep power-down, with no glitch guard. From deep power-down the same count leaves the state in deep power-down.
- R6: From either power-down state, a rise after 10 or more falling edges returns the state to normal. `frame_valid` is high from the chip-select fall to the rise only in frames that started in normal, so the wake-up frame is flagged invalid and the following frame valid.
- R7: In a valid frame the output word is {2'b00, `conv_word` latched at the chip-select fall, zero padding}, sent MSB first. Bit 15 appears one clock after chip select falls, and each later bit appears one clock after a serial-clock falling edge. `sdo_en` is high only while fewer than 16 falling edges have been counted.
- R8: `sdo_en` is low, and `sdo` is 0, in every clock after one in which chip select was sampled high. An aborted frame therefore releases the line immediately.
- R9: A serial-clock falling edge sampled in the same clock as the chip-select rise is included in the count that selects the next state.
- R10: `track` is high whenever the state is normal. In a frame that starts in a power-down state, `track` is low until the first serial-clock edge of either polarity after the chip-select fall, and high after it. It is set again from the new state at the chip-select rise.
- R11: `waking` is high from the chip-select fall to the rise in frames that started in a power-down state, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to `clk` |
| sclk | input | 1 | Serial clock level, synchronous to `clk` |
| conv_word | input | RES_W | Conversion result, latched when chip select falls |
| sdo | output | 1 | Serial data bit, 0 while released |
| sdo_en | output | 1 | Data-pin drive enable (low means high impedance) |
| mode_o | output | 2 | Present power state (0 normal, 1 shallow, 2 deep) |
| frame_valid | output | 1 | Current frame started in normal operation |
| track | output | 1 | Front end is tracking the input |
| waking | output | 1 | Current frame is a wake-up frame |

## Verification
The chip-select rise and a serial-clock falling edge can land in the same system clock. The edge must then still count toward the state decision. The bench provokes this by dropping the serial clock and raising chip select in one step at counts of 2 and 10. At each of these counts, dropping the edge would move the result across a decision threshold, to normal instead of shallow power-down or the reverse. The bench judges the case by the state read from `mode_o` after the rise and by the valid flag of the next frame.

// File: rtl/adc_pm_pkg.sv
// Package adc_pm_pkg
// Shared power-state type and the state-decision function of the tracker.
// Assumes edge counts are passed as plain unsigned integers.
package adc_pm_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'd0,
        PM_SHALLOW = 2'd1,
        PM_DEEP    = 2'd2
    } pm_mode_e;

    // Next state from the present state and the falling-edge count at chip-select rise.
    function automatic pm_mode_e pm_decide(
        input pm_mode_e    cur,
        input int unsigned edges,
        input int unsigned guard,
        input int unsigned wake
    );
        pm_mode_e nxt;
        if (cur == PM_NORMAL) begin
            if (edges < guard || edges >= wake) nxt = PM_NORMAL;
            else                                nxt = PM_SHALLOW;
        end else begin
            if (edges >= wake) nxt = PM_NORMAL;
            else               nxt = PM_DEEP;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/adc_pm_edges.sv
// Module adc_pm_edges
// Keeps one-clock history of chip select and serial clock and derives
// frame boundaries and serial-clock edges. Assumes both inputs are already
// synchronous to clk; the history resets to "idle" (chip select high, clock high).
module adc_pm_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic cs_fall,
    output logic cs_rise,
    output logic in_frame,
    output logic sclk_fall,
    output logic sclk_any
);
    logic cs_q;
    logic sclk_q;

    // Hold the previous sample of both control inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    // Compare present and previous samples to find edges.
    always_comb begin
        cs_fall   = cs_q & ~cs_n;
        cs_rise   = ~cs_q & cs_n;
        in_frame  = ~cs_q & ~cs_n;
        sclk_fall = sclk_q & ~sclk;
        sclk_any  = sclk_q ^ sclk;
    end

endmodule

// File: rtl/adc_pm_counter.sv
// Module adc_pm_counter
// Counts serial-clock falling edges inside a frame, saturating at FRAME_W.
// Also gives the effective count at the chip-select rise, which includes an
// edge sampled in that same clock. Assumes cs_fall restarts the count.
module adc_pm_counter #(
    parameter int FRAME_W = 16,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             in_frame,
    input  logic             sclk_fall,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_eff,
    output logic             cnt_step
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAME_W);

    logic room;

    // Flag a countable edge: in frame (or at the closing rise) with room left.
    always_comb begin
        room     = (cnt < LIMIT);
        cnt_step = sclk_fall & room & (in_frame | cs_rise);
        cnt_eff  = cnt_step ? cnt + 1'b1 : cnt;
    end

    // Restart at each frame start and advance on each counted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cs_fall) begin
            cnt <= '0;
        end else if (in_frame && cnt_step) begin
            cnt <= cnt_eff;
        end
    end

endmodule

// File: rtl/adc_pm_fsm.sv
// Module adc_pm_fsm
// Holds the power state and the per-frame flags (valid, waking, track).
// Assumes the state changes only at a chip-select rise, decided from the
// effective falling-edge count.
module adc_pm_fsm
    import adc_pm_pkg::*;
#(
    parameter int       FRAME_W     = 16,
    parameter int       GUARD_EDGES = 2,
    parameter int       WAKE_EDGES  = 10,
    parameter logic [1:0] INIT_MODE = 2'd0,
    localparam int      CNT_W       = $clog2(FRAME_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             in_frame,
    input  logic             sclk_any,
    input  logic [CNT_W-1:0] cnt_eff,
    output pm_mode_e         mode,
    output logic             frame_valid,
    output logic             waking,
    output logic             track
);
    localparam pm_mode_e INIT_STATE = pm_mode_e'(INIT_MODE);

    pm_mode_e nxt_mode;

    // Evaluate the decision rule for the count reached so far.
    always_comb begin
        nxt_mode = pm_decide(mode, 32'(cnt_eff), GUARD_EDGES, WAKE_EDGES);
    end

    // Power state: updated only when chip select rises.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= INIT_STATE;
        else if (cs_rise) mode <= nxt_mode;
    end

    // Frame flags: set at the frame start from the state, cleared at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid <= 1'b0;
            waking      <= 1'b0;
        end else if (cs_fall) begin
            frame_valid <= (mode == PM_NORMAL);
            waking      <= (mode != PM_NORMAL);
        end else if (cs_rise) begin
            frame_valid <= 1'b0;
            waking      <= 1'b0;
        end
    end

    // Track/hold: resumes on the first clock edge of a wake-up frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  track <= (INIT_STATE == PM_NORMAL);
        else if (cs_rise)                            track <= (nxt_mode == PM_NORMAL);
        else if (in_frame && sclk_any && mode != PM_NORMAL) track <= 1'b1;
    end

endmodule

// File: rtl/adc_pm_shifter.sv
// Module adc_pm_shifter
// Builds the output word at frame start and shifts it MSB first on each
// counted serial-clock falling edge. The pin is enabled only in valid
// frames, before the word is used up, and while the frame is open.
module adc_pm_shifter #(
    parameter int  FRAME_W = 16,
    parameter int  LEAD_W  = 2,
    parameter int  RES_W   = 12,
    localparam int PAD_W   = FRAME_W - LEAD_W - RES_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             in_frame,
    input  logic             cnt_step,
    input  logic [CNT_W-1:0] cnt,
    input  logic             frame_valid,
    input  logic [RES_W-1:0] conv_word,
    output logic             sdo,
    output logic             sdo_en
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic               open_q;
    logic [FRAME_W-1:0] word_in;

    // Assemble the framed word from the result and zero fields.
    generate
        if (PAD_W > 0) begin : g_pad
            assign word_in = {{LEAD_W{1'b0}}, conv_word, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign word_in = {{LEAD_W{1'b0}}, conv_word};
        end
    endgenerate

    // Load at frame start, shift on each counted edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    shreg <= '0;
        else if (cs_fall)              shreg <= word_in;
        else if (in_frame && cnt_step) shreg <= {shreg[FRAME_W-2:0], 1'b0};
    end

    // Frame-open flag for the pin driver.
    always_ff @(posedge clk) begin
        if (!rst_n)       open_q <= 1'b0;
        else if (cs_fall) open_q <= 1'b1;
        else if (cs_rise) open_q <= 1'b0;
    end

    // Pin drive: enabled only inside a valid, unfinished frame.
    always_comb begin
        sdo_en = open_q & frame_valid & (cnt < LIMIT);
        sdo    = sdo_en & shreg[FRAME_W-1];
    end

endmodule

// File: rtl/adc_pm_tracker.sv
// Module adc_pm_tracker
// Top of the serial-ADC power-state tracker: edge detection, falling-edge
// counter, power-state machine and output shifter. Assumes cs_n and sclk are
// synchronous to clk and that each serial-clock level lasts at least one clk.
module adc_pm_tracker #(
    parameter int         FRAME_W     = 16,
    parameter int         LEAD_W      = 2,
    parameter int         RES_W       = 12,
    parameter int         GUARD_EDGES = 2,
    parameter int         WAKE_EDGES  = 10,
    parameter logic [1:0] INIT_MODE   = 2'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [RES_W-1:0] conv_word,
    output logic             sdo,
    output logic             sdo_en,
    output logic [1:0]       mode_o,
    output logic             frame_valid,
    output logic             track,
    output logic             waking
);
    import adc_pm_pkg::*;

    localparam int CNT_W = $clog2(FRAME_W + 1);

    logic             cs_fall, cs_rise, in_frame, sclk_fall, sclk_any;
    logic [CNT_W-1:0] cnt, cnt_eff;
    logic             cnt_step;
    pm_mode_e         mode;

    adc_pm_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .in_frame (in_frame),
        .sclk_fall(sclk_fall),
        .sclk_any (sclk_any)
    );

    adc_pm_counter #(.FRAME_W(FRAME_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .in_frame (in_frame),
        .sclk_fall(sclk_fall),
        .cnt      (cnt),
        .cnt_eff  (cnt_eff),
        .cnt_step (cnt_step)
    );

    adc_pm_fsm #(
        .FRAME_W    (FRAME_W),
        .GUARD_EDGES(GUARD_EDGES),
        .WAKE_EDGES (WAKE_EDGES),
        .INIT_MODE  (INIT_MODE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .in_frame   (in_frame),
        .sclk_any   (sclk_any),
        .cnt_eff    (cnt_eff),
        .mode       (mode),
        .frame_valid(frame_valid),
        .waking     (waking),
        .track      (track)
    );

    adc_pm_shifter #(
        .FRAME_W(FRAME_W),
        .LEAD_W (LEAD_W),
        .RES_W  (RES_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .in_frame   (in_frame),
        .cnt_step   (cnt_step),
        .cnt        (cnt),
        .frame_valid(frame_valid),
        .conv_word  (conv_word),
        .sdo        (sdo),
        .sdo_en     (sdo_en)
    );

    assign mode_o = mode;

endmodule

// File: rtl/adc_pm_tracker_chk.sv
// Module adc_pm_tracker_chk
// Port-level temporal checks for adc_pm_tracker, attached by bind.
module adc_pm_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic [1:0] mode_o,
    input logic       frame_valid,
    input logic       sdo_en,
    input logic       track,
    input logic       waking
);
    // R8: chip select high in the previous clock leaves the pin released.
    p_release_on_cs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !sdo_en);

    // R2: with no chip-select change the state holds.
    p_state_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == $past(cs_n)) |=> $stable(mode_o));

    // R5: deep power-down never steps to shallow power-down.
    p_deep_not_shallow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |=> (mode_o != 2'd1));

    // R6: a valid frame only starts from normal operation.
    p_valid_from_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> ($past(mode_o) == 2'd0));

    // R10: normal operation always tracks.
    p_track_in_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> track);

    // R11: a wake-up frame is only seen in a power-down state.
    p_waking_in_pd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        waking |-> (mode_o != 2'd0));

    // R6: the valid and wake-up flags never coincide.
    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(waking && frame_valid));
endmodule

bind adc_pm_tracker adc_pm_tracker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .mode_o     (mode_o),
    .frame_valid(frame_valid),
    .sdo_en     (sdo_en),
    .track      (track),
    .waking     (waking)
);

// File: tb/adc_pm_tracker_test.sv
// Bench for adc_pm_tracker: a vector table of frames walked in order,
// then directed tests for reset, tracking and wake-up flags.
module adc_pm_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W      = 12;
    localparam int NVEC       = 19;
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_n = 1'b1;
    logic             sclk = 1'b1;
    logic [RES_W-1:0] conv_word = '0;
    logic             sdo, sdo_en, frame_valid, track, waking;
    logic [1:0]       mode_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_pm_tracker uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .conv_word(conv_word), .sdo(sdo), .sdo_en(sdo_en), .mode_o(mode_o),
        .frame_valid(frame_valid), .track(track), .waking(waking)
    );

    // Vector fields: {req[3:0], falls[4:0], same_clock_rise, exp_mode[1:0], exp_valid}
    localparam logic [12:0] VEC [0:NVEC-1] = '{
        {4'd7,  5'd16, 1'b0, 2'd0, 1'b1},  // R7 full frame in normal
        {4'd2,  5'd1,  1'b0, 2'd0, 1'b1},  // R2 glitch, stays normal
        {4'd2,  5'd0,  1'b0, 2'd0, 1'b1},  // R2 no edges
        {4'd3,  5'd2,  1'b0, 2'd1, 1'b1},  // R3 lower bound of window
        {4'd6,  5'd16, 1'b0, 2'd0, 1'b0},  // R6 wake-up frame
        {4'd6,  5'd16, 1'b0, 2'd0, 1'b1},  // R6 next frame valid
        {4'd3,  5'd9,  1'b0, 2'd1, 1'b1},  // R3 upper bound of window
        {4'd5,  5'd1,  1'b0, 2'd2, 1'b0},  // R5 no glitch guard
        {4'd5,  5'd9,  1'b0, 2'd2, 1'b0},  // R5 deep stays deep
        {4'd6,  5'd10, 1'b0, 2'd0, 1'b0},  // R6 wake from deep at 10
        {4'd4,  5'd12, 1'b0, 2'd0, 1'b1},  // R4 short but powered
        {4'd9,  5'd10, 1'b1, 2'd0, 1'b1},  // R9 tenth edge with rise
        {4'd9,  5'd2,  1'b1, 2'd1, 1'b1},  // R9 second edge with rise
        {4'd9,  5'd10, 1'b1, 2'd0, 1'b0},  // R9 wake at rise edge
        {4'd7,  5'd16, 1'b0, 2'd0, 1'b1},  // R7 data again
        {4'd3,  5'd5,  1'b0, 2'd1, 1'b1},  // R3 mid window
        {4'd5,  5'd0,  1'b0, 2'd2, 1'b0},  // R5 zero edges from shallow
        {4'd6,  5'd16, 1'b0, 2'd0, 1'b0},  // R6 wake from deep
        {4'd6,  5'd16, 1'b0, 2'd0, 1'b1}   // R6 valid after wake
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Inputs are changed right after a falling clk edge; one step later outputs are read.
    task automatic step();
        @(negedge clk);
    endtask

    // Run one frame and return what was seen on the pins.
    task automatic run_frame(input int n, input bit same, input logic [RES_W-1:0] w,
                             input bit exp_v, output bit got_v,
                             output int en_bad, output logic [15:0] rx);
        rx = '0;
        en_bad = 0;
        conv_word = w;
        cs_n = 1'b0;
        step();
        got_v = frame_valid;
        rx[15] = sdo;
        if (sdo_en !== exp_v) en_bad++;
        for (int k = 1; k <= n; k++) begin
            if (same && k == n) begin
                sclk = 1'b0; cs_n = 1'b1;
                step();
                sclk = 1'b1;
                step();
            end else begin
                sclk = 1'b0;
                step();
                if (k < 16) begin
                    rx[15-k] = sdo;
                    if (sdo_en !== exp_v) en_bad++;
                end else if (sdo_en !== 1'b0) begin
                    en_bad++;
                end
                sclk = 1'b1;
                step();
            end
        end
        if (!same) begin
            cs_n = 1'b1;
            step();
        end
    endtask

    initial begin
        for (int t = 0; t < WATCHDOG; t++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        bit          got_v;
        int          en_bad;
        logic [15:0] rx;
        step();
        step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(mode_o == 2'd0, "R1", "mode after reset", mode_o, 0);
        chk(!sdo_en && !frame_valid && !waking, "R1", "flags after reset",
            {sdo_en, frame_valid, waking}, 0);
        chk(track == 1'b1, "R1", "track after reset", track, 1);

        for (int i = 0; i < NVEC; i++) begin
            logic [12:0]      v = VEC[i];
            string            rq = $sformatf("R%0d", v[12:9]);
            int               n  = int'(v[8:4]);
            logic [RES_W-1:0] w  = RES_W'(12'h5A3 + i * 12'h1F7);
            run_frame(n, v[3], w, v[0], got_v, en_bad, rx);
            chk(got_v == v[0], "R6", $sformatf("frame_valid vec %0d", i), got_v, v[0]);
            chk(en_bad == 0, "R7", $sformatf("sdo_en pattern vec %0d", i), en_bad, 0);
            if (n == 16 && v[0])
                chk(rx == {2'b00, w, 2'b00}, "R7", $sformatf("word vec %0d", i),
                    rx, {2'b00, w, 2'b00});
            chk(mode_o == v[2:1], rq, $sformatf("state vec %0d", i), mode_o, v[2:1]);
            chk(sdo_en == 1'b0 && sdo == 1'b0, "R8", $sformatf("release vec %0d", i),
                {sdo_en, sdo}, 0);
        end

        // R8: abort a valid frame mid-word, pin released one clock after the rise
        cs_n = 1'b0; conv_word = 12'hFFF;
        step();
        sclk = 1'b0; step(); sclk = 1'b1; step();
        sclk = 1'b0; step();
        sclk = 1'b1; step();
        sclk = 1'b0; step(); sclk = 1'b1; step();
        sclk = 1'b0; step(); sclk = 1'b1; step();
        chk(sdo_en == 1'b1 && sdo == 1'b1, "R7", "mid-word bit", {sdo_en, sdo}, 3);
        cs_n = 1'b1;
        step();
        chk(sdo_en == 1'b0, "R8", "abort release", sdo_en, 0);
        // four edges from normal went to shallow power-down
        chk(mode_o == 2'd1, "R3", "state after abort", mode_o, 1);
        chk(track == 1'b0, "R10", "hold in shallow", track, 0);

        // R10 / R11: wake-up frame flags
        cs_n = 1'b0;
        step();
        chk(track == 1'b0 && waking == 1'b1, "R11", "wake frame start",
            {track, waking}, 1);
        sclk = 1'b0;
        step();
        chk(track == 1'b1, "R10", "track after first edge", track, 1);
        sclk = 1'b1;
        step();
        for (int k = 0; k < 9; k++) begin
            sclk = 1'b0; step(); sclk = 1'b1; step();
        end
        cs_n = 1'b1;
        step();
        chk(mode_o == 2'd0 && waking == 1'b0 && track == 1'b1, "R11", "after wake",
            {mode_o, waking, track}, 5'b00001);

        // R1: reset in the middle of a frame
        run_frame(3, 1'b0, 12'h123, 1'b1, got_v, en_bad, rx);
        cs_n = 1'b0;
        step();
        rst_n = 1'b0;
        step();
        cs_n = 1'b1;
        step();
        rst_n = 1'b1;
        step();
        chk(mode_o == 2'd0 && !sdo_en && !frame_valid && !waking && track, "R1",
            "mid-frame reset", {mode_o, sdo_en, frame_valid, waking, track}, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule